// File: doc/BRIEF.md
# Branch Condition Evaluation Unit

This block settles control flow for a small eBPF-style core. Each cycle it takes one 8-bit opcode together with the current program counter, the 64-bit value of the destination register, a 64-bit register source, a 32-bit immediate and a signed 16-bit displacement. One clock later it presents three results: whether a relative branch is taken, the program counter of the next instruction, and a flag for each of the two control-transfer opcodes that leave the program, call and exit.

The unit only decides. It holds no register file and fetches nothing. The syscall and the exit sequence are left to the surrounding core, which reacts to the flags. All results pass through one output register stage with a synchronous active-low reset. The result for the inputs seen at clock edge t is visible after edge t.

Top module: `bcu_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are all zero. Once reset is released, the outputs after edge t reflect the inputs sampled at edge t.
- R2: An opcode is in the jump class when bits 2:0 equal 3'b101. Bit 3 selects the second operand: 0 selects the immediate and 1 selects `src_i`. Bits 7:4 select the operation: 0 always, 1 equal, 2 unsigned greater, 3 unsigned greater-or-equal, 4 bit test, 5 not equal, 6 signed greater, 7 signed greater-or-equal, 8 call, 9 exit, A unsigned less, B unsigned less-or-equal, C signed less, D signed less-or-equal.
- R3: Equal (0x15/0x1d) is taken when the operands match. Not equal (0x55/0x5d) is taken when they differ. Bit test (0x45/0x4d) is taken when the AND of the operands is non-zero.
- R4: The unsigned compares 0x25/0x2d, 0x35/0x3d, 0xa5/0xad and 0xb5/0xbd treat both 64-bit operands as unsigned.
- R5: The signed compares 0x65/0x6d, 0x75/0x7d, 0xc5/0xcd and 0xd5/0xdd treat both 64-bit operands as two's complement.
- R6: In the immediate forms, the 32-bit immediate is sign-extended to 64 bits before any comparison.
- R7: Opcode 0x05 is always taken. The encoding 0x0d is not a jump.
- R8: When a branch is taken, the next PC is PC + 8 + 8 × (sign-extended displacement), computed modulo 2^64.
- R9: When a branch is not taken, the next PC is PC + 8, computed modulo 2^64.
- R10: Opcode 0x85 raises `call_o` and opcode 0x95 raises `exit_o`. Neither of them is taken, and the next PC for both is PC + 8. The encodings 0x8d and 0x9d raise nothing.
- R11: Any other opcode gives taken 0, no flags and a next PC of PC + 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode_i | input | 8 | Instruction opcode |
| pc_i | input | 64 | Program counter of the instruction |
| dst_i | input | 64 | Destination register value (first operand) |
| src_i | input | 64 | Source register value |
| imm_i | input | 32 | Immediate field |
| off_i | input | 16 | Signed branch displacement in instructions |
| taken_o | output | 1 | Relative branch taken |
| next_pc_o | output | 64 | Address of the next instruction |
| call_o | output | 1 | Call request |
| exit_o | output | 1 | Program exit |

## Verification
Suppose the decoder maps an opcode nibble to the wrong condition, or picks the wrong operand source. The error shows one cycle later as a wrong `taken_o`, and the same cycle `next_pc_o` moves to the fall-through address instead of the target, or the reverse. A wrong displacement scale or a wrong sign extension shows only in `next_pc_o`, and only on taken branches. A missed immediate sign extension shows only for operands whose high words separate the two extensions. A stray flag shows as `call_o` or `exit_o` rising together with, or instead of, `taken_o`. The bench sweeps every opcode against operand sets that sit on the signed/unsigned and sign-extension boundaries, so each of these errors appears on the very next output.

// File: rtl/bcu_pkg.sv
// Shared types for the branch condition unit.
// Assumes jump-class opcodes carry 3'b101 in bits 2:0.
package bcu_pkg;

    localparam logic [2:0] JMP_CLASS = 3'b101;

    typedef enum logic [3:0] {
        COND_NONE,
        COND_ALWAYS,
        COND_EQ,
        COND_NE,
        COND_SET,
        COND_UGT,
        COND_UGE,
        COND_ULT,
        COND_ULE,
        COND_SGT,
        COND_SGE,
        COND_SLT,
        COND_SLE
    } cond_e;

    typedef struct packed {
        cond_e cond;
        logic  use_reg;
        logic  is_call;
        logic  is_exit;
    } dec_t;

endpackage

// File: rtl/bcu_decode.sv
// Opcode decoder: turns an 8-bit opcode into a condition kind, an operand source
// select and the call and exit flags. Purely combinational.
// Assumes the only valid jump class is 3'b101; every other opcode decodes to nothing.
module bcu_decode
    import bcu_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);

    // Map the operation nibble to a condition; bit 3 selects the source.
    always_comb begin
        dec         = '0;
        dec.cond    = COND_NONE;
        dec.use_reg = opcode[3];
        if (opcode[2:0] == JMP_CLASS) begin
            unique case (opcode[7:4])
                4'h0: dec.cond = opcode[3] ? COND_NONE : COND_ALWAYS;
                4'h1: dec.cond = COND_EQ;
                4'h2: dec.cond = COND_UGT;
                4'h3: dec.cond = COND_UGE;
                4'h4: dec.cond = COND_SET;
                4'h5: dec.cond = COND_NE;
                4'h6: dec.cond = COND_SGT;
                4'h7: dec.cond = COND_SGE;
                4'h8: dec.is_call = !opcode[3];
                4'h9: dec.is_exit = !opcode[3];
                4'ha: dec.cond = COND_ULT;
                4'hb: dec.cond = COND_ULE;
                4'hc: dec.cond = COND_SLT;
                4'hd: dec.cond = COND_SLE;
                default: dec.cond = COND_NONE;
            endcase
        end
    end

endmodule

// File: rtl/bcu_compare.sv
// Condition evaluator: compares two operands under the selected condition.
// Assumes both operands are already XLEN bits wide, with any immediate already extended.
module bcu_compare
    import bcu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cond_e            cond,
    input  logic [XLEN-1:0]  lhs,
    input  logic [XLEN-1:0]  rhs,
    output logic             taken
);

    logic eq, ult, slt;

    // Base relations that every condition is built from.
    always_comb begin
        eq  = (lhs == rhs);
        ult = (lhs < rhs);
        slt = ($signed(lhs) < $signed(rhs));
    end

    // Select the relation named by the condition.
    always_comb begin
        unique case (cond)
            COND_ALWAYS: taken = 1'b1;
            COND_EQ:     taken = eq;
            COND_NE:     taken = !eq;
            COND_SET:    taken = |(lhs & rhs);
            COND_UGT:    taken = !ult && !eq;
            COND_UGE:    taken = !ult;
            COND_ULT:    taken = ult;
            COND_ULE:    taken = ult || eq;
            COND_SGT:    taken = !slt && !eq;
            COND_SGE:    taken = !slt;
            COND_SLT:    taken = slt;
            COND_SLE:    taken = slt || eq;
            default:     taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcu_target.sv
// Next-PC generator: adds the instruction size for a fall-through, and the scaled,
// sign-extended displacement on top of that when the branch is taken.
// Assumes INSN_BYTES is a power of two.
module bcu_target #(
    parameter int PC_W       = 64,
    parameter int OFF_W      = 16,
    parameter int INSN_BYTES = 8
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    input  logic             taken,
    output logic [PC_W-1:0]  next_pc
);

    localparam int SHIFT = $clog2(INSN_BYTES);

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] disp;

    // Fall-through address and the displacement scaled to bytes.
    always_comb begin
        seq_pc  = pc + PC_W'(INSN_BYTES);
        disp    = {{(PC_W-OFF_W){off[OFF_W-1]}}, off} << SHIFT;
        next_pc = taken ? seq_pc + disp : seq_pc;
    end

endmodule

// File: rtl/bcu_top.sv
// Branch condition unit top. It decodes the opcode, picks the second operand
// (register, or sign-extended immediate), evaluates the condition, forms the
// next PC and registers every result. Latency is one cycle.
// Assumes a synchronous active-low reset; the outputs are zero while it is held.
module bcu_top
    import bcu_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int IMM_W      = 32,
    parameter int OFF_W      = 16,
    parameter int INSN_BYTES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       opcode_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  dst_i,
    input  logic [XLEN-1:0]  src_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [OFF_W-1:0] off_i,
    output logic             taken_o,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             call_o,
    output logic             exit_o
);

    dec_t            dec;
    logic [XLEN-1:0] rhs;
    logic            taken_c;
    logic [XLEN-1:0] next_pc_c;

    bcu_decode u_decode (
        .opcode (opcode_i),
        .dec    (dec)
    );

    // Second operand: the register, or the sign-extended immediate.
    always_comb begin
        rhs = dec.use_reg ? src_i : {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end

    bcu_compare #(.XLEN(XLEN)) u_compare (
        .cond  (dec.cond),
        .lhs   (dst_i),
        .rhs   (rhs),
        .taken (taken_c)
    );

    bcu_target #(.PC_W(XLEN), .OFF_W(OFF_W), .INSN_BYTES(INSN_BYTES)) u_target (
        .pc      (pc_i),
        .off     (off_i),
        .taken   (taken_c),
        .next_pc (next_pc_c)
    );

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o   <= 1'b0;
            next_pc_o <= '0;
            call_o    <= 1'b0;
            exit_o    <= 1'b0;
        end else begin
            taken_o   <= taken_c;
            next_pc_o <= next_pc_c;
            call_o    <= dec.is_call;
            exit_o    <= dec.is_exit;
        end
    end

    // Byte displacement formed by multiplication, separately from the shifter, for the checks.
    logic [XLEN-1:0] chk_disp;
    always_comb chk_disp = {{(XLEN-OFF_W){off_i[OFF_W-1]}}, off_i} * XLEN'(INSN_BYTES);

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!taken_o && !call_o && !exit_o && next_pc_o == '0)); // R1
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({taken_o, call_o, exit_o})); // R10
    AST_CALL_RAISED: assert property (@(posedge clk) disable iff (!rst_n) (opcode_i == 8'h85) |=> (call_o && !taken_o)); // R10
    AST_EXIT_RAISED: assert property (@(posedge clk) disable iff (!rst_n) (opcode_i == 8'h95) |=> (exit_o && !taken_o)); // R10
    AST_JA_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (opcode_i == 8'h05) |=> taken_o); // R7
    AST_OTHER_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (opcode_i[2:0] != 3'b101) |=> (!taken_o && !call_o && !exit_o)); // R11
    AST_FALLTHROUGH_PC: assert property (@(posedge clk) disable iff (!rst_n) rst_n |=> (taken_o || next_pc_o == $past(pc_i) + XLEN'(INSN_BYTES))); // R9
    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n) rst_n |=> (!taken_o || next_pc_o == $past(pc_i) + XLEN'(INSN_BYTES) + $past(chk_disp))); // R8

endmodule

// File: tb/test_bcu_top.sv
`timescale 1ns/1ps
// Sweeps every opcode against twelve operand sets and checks each registered result
// against a model of the requirements written in the bench.
module test_bcu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [63:0] pc_i = '0, dst_i = '0, src_i = '0;
    logic [31:0] imm_i = '0;
    logic [15:0] off_i = '0;
    logic        taken_o, call_o, exit_o;
    logic [63:0] next_pc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bcu_top i_bcu_top (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .pc_i(pc_i),
        .dst_i(dst_i), .src_i(src_i), .imm_i(imm_i), .off_i(off_i),
        .taken_o(taken_o), .next_pc_o(next_pc_o), .call_o(call_o), .exit_o(exit_o)
    );

    // Operand set v: destination, source, immediate, pc and displacement.
    task automatic load_set(input int v);
        case (v)
            0:  begin dst_i = 64'd5; src_i = 64'd5; imm_i = 32'd5; pc_i = 64'h1000; off_i = 16'd0; end
            1:  begin dst_i = 64'd5; src_i = 64'd7; imm_i = 32'd7; pc_i = 64'h2000; off_i = 16'd1; end
            2:  begin dst_i = 64'd7; src_i = 64'd5; imm_i = 32'd5; pc_i = 64'h3000; off_i = 16'hffff; end
            3:  begin dst_i = '1; src_i = 64'd1; imm_i = 32'd1; pc_i = 64'hffff_ffff_ffff_fff8; off_i = 16'd3; end
            4:  begin dst_i = 64'd1; src_i = '1; imm_i = 32'hffff_ffff; pc_i = 64'h40; off_i = 16'h8000; end
            5:  begin dst_i = '1; src_i = 64'd0; imm_i = 32'hffff_ffff; pc_i = 64'h5000; off_i = 16'h7fff; end
            6:  begin dst_i = 64'h8000_0000_0000_0000; src_i = 64'h7fff_ffff_ffff_ffff; imm_i = 32'h7fff_ffff; pc_i = 64'h6000; off_i = 16'hfff9; end
            7:  begin dst_i = 64'h0000_0000_ffff_ffff; src_i = '1; imm_i = 32'hffff_ffff; pc_i = 64'h7000; off_i = 16'd5; end
            8:  begin dst_i = 64'hf0; src_i = 64'h0f; imm_i = 32'h0f; pc_i = 64'h8000; off_i = 16'd2; end
            9:  begin dst_i = 64'hf0; src_i = 64'h10; imm_i = 32'h10; pc_i = 64'h9000; off_i = 16'hfffe; end
            10: begin dst_i = 64'd0; src_i = 64'd0; imm_i = 32'd0; pc_i = 64'ha000; off_i = 16'd4; end
            default: begin dst_i = 64'h8000_0000_0000_0000; src_i = 64'h8000_0000_0000_0000; imm_i = 32'h8000_0000; pc_i = 64'hb000; off_i = 16'd6; end
        endcase
    endtask

    // Expected results from the requirements.
    task automatic model(input logic [7:0] op, output bit t, output bit c, output bit e, output logic [63:0] npc);
        logic [63:0] b;
        logic signed [63:0] sa, sb;
        b  = op[3] ? src_i : {{32{imm_i[31]}}, imm_i};  // R2 source bit, R6 sign extension
        sa = dst_i; sb = b;
        t = 0; c = 0; e = 0;
        case (op)
            8'h05:        t = 1;                        // R7
            8'h15, 8'h1d: t = (dst_i == b);             // R3
            8'h55, 8'h5d: t = (dst_i != b);
            8'h45, 8'h4d: t = ((dst_i & b) != 0);
            8'h25, 8'h2d: t = (dst_i > b);              // R4
            8'h35, 8'h3d: t = (dst_i >= b);
            8'ha5, 8'had: t = (dst_i < b);
            8'hb5, 8'hbd: t = (dst_i <= b);
            8'h65, 8'h6d: t = (sa > sb);                // R5
            8'h75, 8'h7d: t = (sa >= sb);
            8'hc5, 8'hcd: t = (sa < sb);
            8'hd5, 8'hdd: t = (sa <= sb);
            8'h85:        c = 1;                        // R10
            8'h95:        e = 1;
            default:      ;                             // R11
        endcase
        npc = pc_i + 64'd8;
        if (t) npc = npc + ({{48{off_i[15]}}, off_i} * 64'd8);
    endtask

    function automatic string tag(input logic [7:0] op);
        case (op)
            8'h05: return "R7";
            8'h15, 8'h1d, 8'h55, 8'h5d, 8'h45, 8'h4d: return op[3] ? "R3" : "R3/R6";
            8'h25, 8'h2d, 8'h35, 8'h3d, 8'ha5, 8'had, 8'hb5, 8'hbd: return op[3] ? "R4" : "R4/R6";
            8'h65, 8'h6d, 8'h75, 8'h7d, 8'hc5, 8'hcd, 8'hd5, 8'hdd: return op[3] ? "R5" : "R5/R6";
            8'h85, 8'h95: return "R10";
            default: return "R11";
        endcase
    endfunction

    initial begin
        bit t, c, e;
        logic [63:0] npc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (taken_o !== 0 || call_o !== 0 || exit_o !== 0 || next_pc_o !== 0) begin
            fails++;
            $display("FAIL R1 reset: taken=%0b call=%0b exit=%0b pc=%h expected all zero", taken_o, call_o, exit_o, next_pc_o);
        end
        rst_n = 1'b1;
        for (int op = 0; op < 256; op++) begin
            for (int v = 0; v < 12; v++) begin
                opcode_i = 8'(op);
                load_set(v);
                model(8'(op), t, c, e, npc);
                @(posedge clk);
                @(negedge clk);
                checks++;
                if (taken_o !== t || call_o !== c || exit_o !== e) begin
                    fails++;
                    $display("FAIL %s op=%h set=%0d: taken/call/exit=%0b%0b%0b expected %0b%0b%0b",
                             tag(8'(op)), op, v, taken_o, call_o, exit_o, t, c, e);
                end
                checks++;
                if (next_pc_o !== npc) begin
                    fails++;
                    $display("FAIL %s op=%h set=%0d: next_pc=%h expected %h",
                             t ? "R8" : "R9", op, v, next_pc_o, npc);
                end
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule